// File: doc/BRIEF.md
# Floating-Point Compare with Condition Flags

This block orders two IEEE-754 operands and folds the outcome into a 32-bit image of the floating-point control register. Each operand arrives on a 64-bit word. A precision select tells the block to read the full word as a double or only its low 32 bits as a single. The caller presents the operands, the precision select and the current register image, then pulses a start strobe. One cycle later the block returns the updated register image, a trap request and a valid flag.

Before it orders the operands, the block treats an operand with a zero exponent field as zero. This covers true zeros and denormals of either sign. Any NaN makes the result unordered. A signalling NaN can instead raise the invalid-operation cause, but only when the invalid trap is enabled in the incoming image. A compare never sets any other cause.

Register image layout (bit positions). Each 5-bit flag field has V at its top bit, then Z, O, U, with I at its bottom bit.
- Enable field: bits [4:0]. V is bit 4.
- Cause field: bits [12:8]. V is bit 12.
- Condition code: bits [19:16], one-hot, with U = bit 16, E = bit 17, G = bit 18, L = bit 19.

Top module: `fcmp_flag_unit`

## Requirements
- R1: On every start, all five cause bits [12:8] and all four condition-code bits [19:16] of the incoming image are cleared before the new outcome is written. No stale bit from the image or from a previous compare survives.
- R2: Every bit of the image outside [12:8] and [19:16] is returned unchanged from the value presented with start.
- R3: If either operand is a signalling NaN and enable bit 4 (invalid) is set, cause bit 12 is set and the condition code stays all zero. This applies even when the other operand is a quiet NaN. A signalling NaN has an all-ones exponent, a non-zero fraction and a fraction MSB of 0.
- R4: If either operand is a signalling NaN and enable bit 4 is clear, the condition code is unordered (bit 16) and no cause bit is set.
- R5: If an operand is a quiet NaN and neither operand is signalling, the condition code is unordered (bit 16) whatever the enables, and no cause bit is set. A quiet NaN has an all-ones exponent and a fraction MSB of 1.
- R6: For ordered operands, the code is L (bit 19) when the first operand is smaller, G (bit 18) when it is larger and E (bit 17) when the two are equal. Infinities order beyond every finite value, and a difference in the lowest fraction bit counts.
- R7: An operand whose exponent field is zero compares as zero, including denormals of either sign. +0 and -0 compare equal.
- R8: trap_o is high exactly when the returned image has a cause bit set. With no cause set, nothing is signalled.
- R9: dbl_i = 1 compares the full 64-bit words as doubles. dbl_i = 0 compares bits [31:0] as singles, and bits [63:32] have no effect.
- R10: valid_o is high in the cycle after each start cycle and low otherwise. Back-to-back starts give back-to-back results. Between starts, ctl_o and trap_o hold their last values whatever the other inputs do. Reset sets ctl_o, trap_o and valid_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches a compare of the current inputs |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| ctl_i | input | 32 | Current control register image (enables, stale causes and code) |
| ctl_o | output | 32 | Updated control register image |
| trap_o | output | 1 | Trap request, high while a cause bit is set in ctl_o |
| valid_o | output | 1 | High for one cycle when ctl_o carries a new result |

## Verification
Two functions can land in the same cycle. The first is clearing a previous result: a start with an enabled signalling NaN raises a trap, and the next start, in the very next cycle, has to clear it. The second is the precedence between the invalid cause and the unordered code, which both apply when one operand is a signalling NaN and the other a quiet NaN. The bench provokes the first with back-to-back starts whose stale images have every bit set. It provokes the second with mixed NaN pairs under both settings of the invalid enable. The scoreboard judges each returned image as a whole against a model that orders the operands as real numbers.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register field positions and operand types for
// the compare unit. Assumes a 32-bit control register image.
package fcmp_pkg;
    localparam int DW        = 64;
    localparam int SP_EXP    = 8;
    localparam int SP_FRAC   = 23;
    localparam int SP_W      = SP_EXP + SP_FRAC + 1;
    localparam int DP_EXP    = 11;
    localparam int DP_FRAC   = 52;
    localparam int MAG_W     = DP_EXP + DP_FRAC;

    localparam int CTL_W     = 32;
    localparam int FLD_W     = 5;
    localparam int CC_W      = 4;
    localparam int EN_LSB    = 0;
    localparam int CAUSE_LSB = 8;
    localparam int CC_LSB    = 16;

    // flag index inside an enable or cause field
    localparam int F_I = 0;
    localparam int F_U = 1;
    localparam int F_O = 2;
    localparam int F_Z = 3;
    localparam int F_V = 4;

    // condition code index inside the code field
    localparam int CC_U = 0;
    localparam int CC_E = 1;
    localparam int CC_G = 2;
    localparam int CC_L = 3;

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_GT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;
endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
// Operand classifier: splits one IEEE-754 word of the given format into
// its sign, a flushed magnitude key and the NaN and zero classes.
// Assumes: a zero exponent field means zero (denormals are flushed), and
// the magnitude key fits in MAG_W bits.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output opnd_t                 cls_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;

    assign expo     = word_i[WORD_W-2 -: EXP_W];
    assign frac     = word_i[FRAC_W-1:0];
    assign exp_ones = &expo;
    assign exp_zero = ~|expo;

    // Build the class record; a flushed operand gets a zero magnitude key.
    always_comb begin
        cls_o      = '0;
        cls_o.sign = word_i[WORD_W-1];
        cls_o.zero = exp_zero;
        cls_o.nan  = exp_ones & (|frac);
        cls_o.snan = exp_ones & (|frac) & ~frac[FRAC_W-1];
        cls_o.mag  = exp_zero ? '0 : MAG_W'({expo, frac});
    end
endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
// Ordering core: relates two classified operands of the same format.
// Assumes magnitude keys that order like the encoded values, with flushed
// operands already zero.
module fcmp_order
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_e  rel_o,
    output logic  inv_o
);
    logic mag_eq;
    logic mag_lt;

    assign mag_eq = (a_i.mag == b_i.mag);
    assign mag_lt = (a_i.mag <  b_i.mag);
    assign inv_o  = a_i.snan | b_i.snan;

    // Pick the relation: NaN first, then zeros, then sign, then magnitude.
    always_comb begin
        if (a_i.nan || b_i.nan)
            rel_o = REL_UN;
        else if (a_i.zero && b_i.zero)
            rel_o = REL_EQ;
        else if (a_i.sign != b_i.sign)
            rel_o = a_i.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel_o = REL_EQ;
        else if (mag_lt)
            rel_o = a_i.sign ? REL_GT : REL_LT;
        else
            rel_o = a_i.sign ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
`timescale 1ns/1ps
// Compare unit top: classifies both operands in both formats, selects a
// format by dbl_i, orders them and registers the updated control register
// image and trap request one cycle after start.
// Assumes: synchronous active-low reset; the result holds between starts.
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dbl_i,
    input  logic [DW-1:0]    opa_i,
    input  logic [DW-1:0]    opb_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             trap_o,
    output logic             valid_o
);
    localparam logic [CTL_W-1:0] CAUSE_MASK = CTL_W'({FLD_W{1'b1}}) << CAUSE_LSB;
    localparam logic [CTL_W-1:0] CC_MASK    = CTL_W'({CC_W{1'b1}}) << CC_LSB;
    localparam logic [CTL_W-1:0] KEEP_MASK  = ~(CAUSE_MASK | CC_MASK);

    logic [DW-1:0]    op_word [2];
    opnd_t            cls     [2];
    rel_e             rel;
    logic             inv_op;
    logic [CTL_W-1:0] ctl_nxt;
    logic             trap_nxt;
    logic [CTL_W-1:0] ctl_q;
    logic             trap_q;
    logic             valid_q;

    assign op_word[0] = opa_i;
    assign op_word[1] = opb_i;

    // One classifier pair per operand, the format picked by dbl_i.
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        opnd_t sp_cls;
        opnd_t dp_cls;
        fcmp_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
            .word_i (op_word[g][SP_W-1:0]),
            .cls_o  (sp_cls)
        );
        fcmp_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
            .word_i (op_word[g]),
            .cls_o  (dp_cls)
        );
        assign cls[g] = dbl_i ? dp_cls : sp_cls;
    end

    fcmp_order u_ord (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .rel_o (rel),
        .inv_o (inv_op)
    );

    // Build the next image: clear the stale fields, then write the outcome.
    always_comb begin
        ctl_nxt = ctl_i;
        ctl_nxt[CAUSE_LSB +: FLD_W] = '0;
        ctl_nxt[CC_LSB +: CC_W]     = '0;
        if (inv_op && ctl_i[EN_LSB + F_V]) begin
            ctl_nxt[CAUSE_LSB + F_V] = 1'b1;
        end else begin
            unique case (rel)
                REL_LT:  ctl_nxt[CC_LSB + CC_L] = 1'b1;
                REL_GT:  ctl_nxt[CC_LSB + CC_G] = 1'b1;
                REL_EQ:  ctl_nxt[CC_LSB + CC_E] = 1'b1;
                default: ctl_nxt[CC_LSB + CC_U] = 1'b1;
            endcase
        end
        trap_nxt = |ctl_nxt[CAUSE_LSB +: FLD_W];
    end

    // Result register: loads on start, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            trap_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start_i;
            if (start_i) begin
                ctl_q  <= ctl_nxt;
                trap_q <= trap_nxt;
            end
        end
    end

    assign ctl_o   = ctl_q;
    assign trap_o  = trap_q;
    assign valid_o = valid_q;

    // R10
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(ctl_o) && $stable(trap_o) && !valid_o));
    // R2
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ((ctl_o & KEEP_MASK) == ($past(ctl_i) & KEEP_MASK)));
    // R1
    stale_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ctl_o[CAUSE_LSB +: F_V] == '0));
    // R6
    one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !trap_o) |-> $onehot(ctl_o[CC_LSB +: CC_W]));
    // R3
    inv_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (ctl_o[CC_LSB +: CC_W] == '0));
    // R3
    snan_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (cls[0].snan || cls[1].snan) && ctl_i[EN_LSB + F_V]) |=> trap_o);
    // R8
    no_enable_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ctl_i[EN_LSB + F_V]) |=> !trap_o);
endmodule

// File: tb/fcmp_flag_unit_tb.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        dbl_i;
    logic [63:0] opa_i;
    logic [63:0] opb_i;
    logic [31:0] ctl_i;
    logic [31:0] ctl_o;
    logic        trap_o;
    logic        valid_o;

    int checks   = 0;
    int failures = 0;
    bit mon_en   = 1'b0;

    logic [32:0] expq [$];
    string       tagq [$];
    logic [32:0] last_res;
    bit          have_last = 1'b0;

    always #4 clk = ~clk;

    fcmp_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .opa_i(opa_i), .opb_i(opb_i), .ctl_i(ctl_i),
        .ctl_o(ctl_o), .trap_o(trap_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan(input bit dbl, input logic [63:0] w, output bit sig);
        if (dbl) begin
            sig = (&w[62:52]) && (w[51:0] != 0) && !w[51];
            return (&w[62:52]) && (w[51:0] != 0);
        end
        sig = (&w[30:23]) && (w[22:0] != 0) && !w[22];
        return (&w[30:23]) && (w[22:0] != 0);
    endfunction

    function automatic real to_real(input bit dbl, input logic [63:0] w);
        logic [10:0] de;
        if (dbl) begin
            if (w[62:52] == 0) return 0.0;
            return $bitstoreal(w);
        end
        if (w[30:23] == 0) return 0.0;
        if (&w[30:23]) de = 11'h7FF;
        else de = 11'(w[30:23]) + 11'd896;
        return $bitstoreal({w[31], de, w[22:0], 29'd0});
    endfunction

    // Expected {trap, image} from the requirements: R1..R9.
    function automatic logic [32:0] model(input bit dbl, input logic [63:0] a,
                                          input logic [63:0] b, input logic [31:0] ctl);
        logic [31:0] r;
        bit as, bs, an, bn;
        real ra, rb;
        r  = ctl & ~32'h000F_1F00;
        an = is_nan(dbl, a, as);
        bn = is_nan(dbl, b, bs);
        if (as || bs) begin
            if (ctl[4]) r[12] = 1'b1;
            else r[16] = 1'b1;
        end else if (an || bn) begin
            r[16] = 1'b1;
        end else begin
            ra = to_real(dbl, a);
            rb = to_real(dbl, b);
            if (ra < rb) r[19] = 1'b1;
            else if (ra > rb) r[18] = 1'b1;
            else r[17] = 1'b1;
        end
        return {|r[12:8], r};
    endfunction

    task automatic cmp(input bit dbl, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] ctl, input string tag);
        @(negedge clk);
        start_i = 1'b1;
        dbl_i   = dbl;
        opa_i   = a;
        opb_i   = b;
        ctl_i   = ctl;
        expq.push_back(model(dbl, a, b, ctl));
        tagq.push_back(tag);
    endtask

    // Idle cycles with scrambled inputs that must have no effect (R10).
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            start_i = 1'b0;
            opa_i   = opa_i ^ 64'hA5A5_5A5A_0F0F_F0F0;
            ctl_i   = ~ctl_i;
            dbl_i   = ~dbl_i;
        end
    endtask

    // Monitor: pops the scoreboard on each valid, otherwise checks the hold.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (valid_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R10 unexpected valid", {trap_o, ctl_o}, 33'd0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({trap_o, ctl_o} === e, t, {trap_o, ctl_o}, e);
                    last_res  = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check({trap_o, ctl_o} === last_res, "R10 hold", {trap_o, ctl_o}, last_res);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] C_ALL = 32'hFFFF_FFFF;
    localparam logic [31:0] C_NOV = 32'hFFFF_FFEF;
    localparam logic [31:0] C_NIL = 32'h0000_0000;

    initial begin
        rst_n = 1'b0; start_i = 1'b0; dbl_i = 1'b0;
        opa_i = '0; opb_i = '0; ctl_i = C_ALL;
        repeat (3) @(negedge clk);
        check({valid_o, trap_o, ctl_o} === 34'd0, "R10 reset",
              {trap_o, ctl_o}, 33'd0);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // single precision
        cmp(0, 64'h3F80_0000, 64'h4000_0000, C_ALL, "R6 R1 single lt stale cleared");
        cmp(0, 64'h4000_0000, 64'h3F80_0000, C_NIL, "R6 single gt");
        cmp(0, 64'hBF80_0000, 64'h3F80_0000, C_ALL, "R6 single neg lt");
        idle(2);
        cmp(0, 64'h3F80_0000, 64'h3F80_0000, C_ALL, "R6 single eq");
        cmp(0, 64'h0000_0000, 64'h8000_0000, C_ALL, "R7 +0 eq -0");
        cmp(0, 64'h0000_0001, 64'h8000_0000, C_NIL, "R7 denorm eq -0");
        cmp(0, 64'h8040_0000, 64'h0000_0000, C_ALL, "R7 neg denorm eq +0");
        cmp(0, 64'h7F80_0000, 64'h4000_0000, C_ALL, "R6 inf gt");
        cmp(0, 64'hFF80_0000, 64'hBF80_0000, C_ALL, "R6 -inf lt");
        idle(3);
        cmp(0, 64'h7F80_0001, 64'h3F80_0000, C_ALL, "R3 R8 snan enabled trap");
        cmp(0, 64'h3F80_0000, 64'h3F80_0000, C_ALL, "R1 R8 back-to-back clears trap");
        cmp(0, 64'h3F80_0000, 64'h7F80_0001, C_NOV, "R4 snan disabled unordered");
        cmp(0, 64'h7FC0_0000, 64'h3F80_0000, C_ALL, "R5 qnan unordered no trap");
        cmp(0, 64'h7F80_0001, 64'h7FC0_0000, C_ALL, "R3 snan beats qnan");
        cmp(0, 64'h7FC0_0000, 64'h7F80_0001, C_NOV, "R4 qnan snan disabled");
        cmp(0, {32'hFFFF_FFFF, 32'h3F80_0000}, {32'h0, 32'h4000_0000}, C_ALL,
            "R9 single ignores upper bits");
        cmp(0, {32'h7FF8_0000, 32'h4000_0000}, {32'h0, 32'h4000_0000}, C_NIL,
            "R9 single upper nan ignored");
        idle(2);
        // double precision
        cmp(1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, C_ALL, "R9 R6 double lt");
        cmp(1, 64'hC00C_0000_0000_0000, 64'h3FF0_0000_0000_0000, C_NIL, "R6 double neg lt");
        cmp(1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, C_ALL, "R6 double lsb lt");
        cmp(1, 64'h7FEF_FFFF_FFFF_FFFF, 64'hFFF0_0000_0000_0000, C_ALL, "R6 double gt -inf");
        cmp(1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, C_ALL, "R7 double denorm eq");
        cmp(1, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, C_ALL, "R3 R8 double snan trap");
        cmp(1, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, C_NOV, "R5 double qnan");
        cmp(1, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 32'h1234_5678, "R2 passthrough eq");
        cmp(1, 64'h7FF0_0000_0000_0001, 64'h0, 32'hA5A0_E0F4, "R2 R3 passthrough trap");
        idle(4);
        check(expq.size() == 0, "R10 all results seen", 33'(expq.size()), 33'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule